// File: doc/BRIEF.md
# Burst-Request Byte Injector

This block lives inside a bus switch that sits between a host computer and a peripheral on an open-collector serial bus. It does its work just before the switch joins a peripheral to the host. A request flag is latched whenever the host side asks for fast-serial (burst) operation. When the switch later raises a start request and the flag is set, the block clocks an all-ones byte into the device: it produces eight pulses on the bus clock line and holds the data line for the whole of that time. It then waits two further hidden counts with both lines released and gives a one-cycle connect pulse. If the flag is clear, the connect pulse follows the start at once and the bus is left alone.

A ten-state sequence counter times everything. Its states 0 to 7 each carry one visible clock pulse. States 8 and 9 carry none and form the connect delay. The counter parks at its last state while idle. The width of each phase of a pulse comes from a prescaler that counts system clock cycles, so no analog timing is involved. The outputs are pull enables for active-low open-collector lines: 1 pulls the line low and 0 releases it. Only plain control pins are used, because no data stream crosses the block's edge and there is no back-pressure to handle.

Top module: `burst_injector`

## Requirements
- R1: `req_set` arms the burst flag and `req_clr` disarms it, both at the next clock edge. When both are high in one cycle, `req_clr` wins. A start uses the flag value held before that edge.
- R2: A start accepted while the flag is armed produces exactly PULSES (8) low pulses on the bus clock line, which clocks the byte 0xFF into the device.
- R3: `clk_pull` first rises in the cycle after the start is sampled. In each of the first PULSES counter states it is high for HALF_CYC cycles and then low for HALF_CYC cycles.
- R4: `dat_pull` is high from the first cycle of the sequence through the last cycle of the eighth pulse state, 2*PULSES*HALF_CYC cycles in all, and `clk_pull` is never high without it.
- R5: The two hidden states that follow last 2*DELAY_ST*HALF_CYC cycles. During them both pull enables stay low and `busy` stays high, so `busy` lasts 2*(PULSES+DELAY_ST)*HALF_CYC cycles.
- R6: `connect` is high for exactly one cycle, in the cycle after `busy` falls. With the flag disarmed, a start gives `connect` in the next cycle with no bus activity and no `busy`.
- R7: A start that arrives while `busy` is high is ignored. The running sequence continues unchanged and no second sequence follows.
- R8: A synchronous reset disarms the flag, parks the counter at its idle terminal state, releases both lines and clears `busy` and `connect` at the next edge, even in the middle of a sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_set | input | 1 | Arms the burst-request flag |
| req_clr | input | 1 | Disarms the burst-request flag (wins over req_set) |
| start | input | 1 | Connect request from the switch; sampled while idle |
| clk_pull | output | 1 | Pull enable for the bus clock line (1 pulls low) |
| dat_pull | output | 1 | Pull enable for the bus data line (1 pulls low) |
| busy | output | 1 | Injection sequence in progress |
| connect | output | 1 | One-cycle pulse: the device may now be joined to the host |

## Verification
The bench targets the edges of the sequence. It checks the pulse count, so a design whose counter leaked one of the hidden states onto the clock line would be caught with a ninth pulse. It checks the exact cycle where `dat_pull` drops, so a data release that came one phase early or late would be caught. It also covers a start at idle with the flag clear, a set and a clear in the same cycle, a start issued in the middle of a sequence, a start issued in the very cycle that `connect` fires, and a reset in mid-burst. A design that restarted on a late start, or that let set beat clear, would give a different clock-line pattern from the reference model within a few cycles.

// File: rtl/bi_pkg.sv
package bi_pkg;
  typedef enum logic {PH_LOW = 1'b0, PH_HIGH = 1'b1} phase_e;
endpackage

// File: rtl/bi_flag.sv
module bi_flag (
  input  logic clk,
  input  logic rst,
  input  logic req_set,
  input  logic req_clr,
  output logic armed
);
  always_ff @(posedge clk) begin
    if (rst)          armed <= 1'b0;
    else if (req_clr) armed <= 1'b0;
    else if (req_set) armed <= 1'b1;
  end

  assert_clr_wins_R1: assert property (@(posedge clk) disable iff (rst)
    req_clr |=> !armed);
endmodule

// File: rtl/bi_prescale.sv
module bi_prescale #(
  parameter int HALF_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic restart,
  output logic low_phase,
  output logic state_end
);
  import bi_pkg::*;
  localparam int PC_W = $clog2(HALF_CYC + 1);
  localparam logic [PC_W-1:0] PC_LAST = PC_W'(HALF_CYC - 1);

  logic [PC_W-1:0] pc_q;
  phase_e          ph_q;

  always_ff @(posedge clk) begin
    if (rst || restart || !run) begin
      pc_q <= '0;
      ph_q <= PH_LOW;
    end else if (pc_q == PC_LAST) begin
      pc_q <= '0;
      ph_q <= (ph_q == PH_LOW) ? PH_HIGH : PH_LOW;
    end else begin
      pc_q <= pc_q + 1'b1;
    end
  end

  assign low_phase = run && (ph_q == PH_LOW);
  assign state_end = run && (ph_q == PH_HIGH) && (pc_q == PC_LAST);

  assert_pc_range_R3: assert property (@(posedge clk) disable iff (rst)
    pc_q <= PC_LAST);
endmodule

// File: rtl/bi_seq.sv
module bi_seq #(
  parameter int PULSES   = 8,
  parameter int DELAY_ST = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic launch,
  input  logic bypass,
  input  logic state_end,
  output logic busy,
  output logic active,
  output logic connect,
  output logic in_pulse
);
  localparam int TOTAL = PULSES + DELAY_ST;
  localparam int CNT_W = $clog2(TOTAL + 1);
  localparam logic [CNT_W-1:0] LAST_C  = CNT_W'(TOTAL - 1);
  localparam logic [CNT_W-1:0] PULSE_C = CNT_W'(PULSES);

  logic [CNT_W-1:0] cnt_q;
  logic             finish;
  logic             pulses_done;

  assign finish      = busy && state_end && (cnt_q == LAST_C);
  assign pulses_done = busy && state_end && (cnt_q + 1'b1 == PULSE_C);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= LAST_C;
      busy  <= 1'b0;
    end else if (launch) begin
      cnt_q <= '0;
      busy  <= 1'b1;
    end else if (finish) begin
      busy  <= 1'b0;
    end else if (busy && state_end) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // set (start) has priority over clear (terminal pulse count)
  always_ff @(posedge clk) begin
    if (rst)              active <= 1'b0;
    else if (launch)      active <= 1'b1;
    else if (pulses_done) active <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) connect <= 1'b0;
    else     connect <= finish || bypass;
  end

  assign in_pulse = (cnt_q < PULSE_C);

  assert_no_restart_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && !launch) |=> (cnt_q >= $past(cnt_q)));
  assert_park_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (cnt_q == LAST_C));
  assert_conn_one_R6: assert property (@(posedge clk) disable iff (rst)
    connect |=> !connect || $past(bypass) || $past(finish));
  assert_active_span_R4: assert property (@(posedge clk) disable iff (rst)
    active == (busy && in_pulse));
endmodule

// File: rtl/burst_injector.sv
module burst_injector #(
  parameter int PULSES   = 8,
  parameter int DELAY_ST = 2,
  parameter int HALF_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic req_set,
  input  logic req_clr,
  input  logic start,
  output logic clk_pull,
  output logic dat_pull,
  output logic busy,
  output logic connect
);
  logic armed, launch, bypass, accept;
  logic low_phase, state_end, active, in_pulse;

  assign accept = start && !busy;
  assign launch = accept && armed;
  assign bypass = accept && !armed;

  bi_flag u_flag (
    .clk(clk), .rst(rst), .req_set(req_set), .req_clr(req_clr), .armed(armed)
  );

  bi_prescale #(.HALF_CYC(HALF_CYC)) u_pre (
    .clk(clk), .rst(rst), .run(busy), .restart(launch),
    .low_phase(low_phase), .state_end(state_end)
  );

  bi_seq #(.PULSES(PULSES), .DELAY_ST(DELAY_ST)) u_seq (
    .clk(clk), .rst(rst), .launch(launch), .bypass(bypass),
    .state_end(state_end), .busy(busy), .active(active),
    .connect(connect), .in_pulse(in_pulse)
  );

  // clock gate: hidden states never reach the bus
  assign clk_pull = low_phase && in_pulse;
  assign dat_pull = active;

  assert_clk_under_dat_R4: assert property (@(posedge clk) disable iff (rst)
    clk_pull |-> dat_pull);
  assert_conn_idle_R6: assert property (@(posedge clk) disable iff (rst)
    connect |-> !busy);
  assert_reset_clear_R8: assert property (@(posedge clk)
    $past(rst) |-> (!busy && !clk_pull && !dat_pull && !connect));
  assert_launch_pull_R3: assert property (@(posedge clk) disable iff (rst)
    launch |=> (clk_pull && dat_pull));
endmodule

// File: tb/burst_injector_tb.sv
module burst_injector_tb;
  localparam int P  = 8;
  localparam int D  = 2;
  localparam int H  = 4;
  localparam int ST = 2 * H;
  localparam int TOT = (P + D) * ST;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_set = 1'b0, req_clr = 1'b0, start = 1'b0;
  logic clk_pull, dat_pull, busy, connect;

  int total = 0, bad = 0;
  bit m_run = 0, m_flag = 0, m_conn = 0, m_seqflag = 0;
  int m_t = 0;
  int pulses = 0;
  logic prev_clk = 1'b0;

  always #5 clk = ~clk;

  burst_injector #(.PULSES(P), .DELAY_ST(D), .HALF_CYC(H)) u_dut (
    .clk(clk), .rst(rst), .req_set(req_set), .req_clr(req_clr), .start(start),
    .clk_pull(clk_pull), .dat_pull(dat_pull), .busy(busy), .connect(connect)
  );

  // behavioural reference, advanced on every clock edge
  always @(posedge clk) begin
    if (rst) begin
      m_run = 0; m_flag = 0; m_conn = 0; m_t = 0; m_seqflag = 0;
    end else begin
      m_conn = 0;
      if (m_run) begin
        if (m_t == TOT - 1) begin m_run = 0; m_conn = 1; end
        else m_t++;
      end else if (start) begin
        if (m_flag) begin m_run = 1; m_t = 0; m_seqflag = 1; end
        else begin m_conn = 1; m_seqflag = 0; end
      end
      if (req_clr) m_flag = 0;
      else if (req_set) m_flag = 1;
    end
  end

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk("R3", "clk_pull", clk_pull,
          m_run && (m_t < P * ST) && ((m_t % ST) < H));
      chk("R4", "dat_pull", dat_pull, m_run && (m_t < P * ST));
      chk("R5", "busy", busy, m_run);
      chk("R6", "connect", connect, m_conn);
      if (clk_pull && !prev_clk) pulses++;
      if (connect) begin
        total++;
        if (pulses != (m_seqflag ? P : 0)) begin
          bad++;
          $display("FAIL R2 pulse count actual=%0d expected=%0d", pulses, m_seqflag ? P : 0);
        end
        pulses = 0;
      end
    end else pulses = 0;
    prev_clk = clk_pull;
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_start();
    start = 1'b1; @(negedge clk); start = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cyc(3);
    // R8: reset state
    total++;
    if (clk_pull || dat_pull || busy || connect) begin
      bad++; $display("FAIL R8 reset outputs actual=%0b%0b%0b%0b expected=0000",
                      clk_pull, dat_pull, busy, connect);
    end
    rst = 1'b0; cyc(2);
    // R6: flag disarmed, start gives immediate connect
    pulse_start(); cyc(5);
    // R1, R2: arm and run a full byte
    req_set = 1'b1; @(negedge clk); req_set = 1'b0;
    pulse_start(); cyc(TOT + 5);
    // R7: starts during the sequence are ignored
    pulse_start(); cyc(7); pulse_start(); cyc(P * ST); pulse_start();
    cyc(TOT);
    // R7/R6: start held across the connect cycle relaunches only after idle
    start = 1'b1; cyc(2 * TOT + 4); start = 1'b0; cyc(4);
    // R1: set and clear together leave the flag disarmed
    req_set = 1'b1; req_clr = 1'b1; @(negedge clk); req_set = 1'b0; req_clr = 1'b0;
    pulse_start(); cyc(6);
    // R1: start in the same cycle as set uses the old flag
    req_set = 1'b1; start = 1'b1; @(negedge clk); req_set = 1'b0; start = 1'b0;
    cyc(4);
    pulse_start(); cyc(TOT / 2);
    // R8: reset mid-burst
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    total++;
    if (busy || clk_pull || dat_pull) begin
      bad++; $display("FAIL R8 mid-burst reset actual=%0b%0b%0b expected=000",
                      busy, clk_pull, dat_pull);
    end
    pulses = 0;
    // R8: flag disarmed by reset
    pulse_start(); cyc(6);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule